// File: doc/BRIEF.md
# Clock-Enable Divider with External Clock Output

This block runs on one fast clock and produces two outputs that pace slower logic without building a second clock tree. A modulo-25 counter produces a clock-enable strobe that is high for a single fast cycle in every 25. Downstream counters, comparators and other registers stay on the fast clock and load only while the strobe is high. The same counter also drives a registered, near-square external clock at the divided rate. Its rising edge is locked to the strobe. With a 36 MHz fast clock, the strobe rate and the external clock are both 1.44 MHz.

The strobe and the external clock each come straight from a flip-flop, so neither output can glitch. No logic runs on a gated or derived clock. Reset is asynchronous and active low. The block releases it internally through a two-stage synchronizer, so the count restarts a fixed number of edges after `rst_n_i` rises.

Top module: `ce_clk_divider`

## Requirements
- R1: While `rst_n_i` is low, `tick_o` and `ext_clk_o` are both low. Asserting `rst_n_i` low forces them low at once, without waiting for a clock edge.
- R2: The internal counter holds only the values 0 to 24. It advances by one on each enabled edge and returns to 0 after 24, so the output pattern repeats every 25 fast cycles.
- R3: `tick_o` is high for exactly one fast cycle in every 25, and two consecutive pulses start 25 cycles apart.
- R4: When `rst_n_i` rises between clock edges, counting starts after two synchronizer edges. `tick_o` first goes high after the 26th rising edge following the release, and again after every 25 edges from then on.
- R5: `ext_clk_o` rises on the same clock edge on which `tick_o` rises, in every period.
- R6: After each rise, `ext_clk_o` stays high for exactly 12 fast cycles and then low for 13.
- R7: After reset, `ext_clk_o` stays low until the first `tick_o` pulse. There is no shortened first high phase.
- R8: A reset applied in the middle of a run restarts the whole pattern. The timing after the new release is identical to the timing after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| tick_o | output | 1 | One-cycle clock-enable strobe, once every 25 cycles |
| ext_clk_o | output | 1 | Registered divided clock, high 12 of 25 cycles |

## Verification
Two events share one edge: the strobe firing and the external clock rising. The external clock's falling edge is a separate event, 12 cycles after them. The bench provokes all of these by releasing reset on a falling edge and counting rising edges. It predicts both outputs from that edge count alone and compares them after every edge, over several periods. This shows whether the rise and the strobe share an edge. It also shows whether the fall lands exactly 12 cycles later, without slipping by one. The bench then asserts reset in the middle of a high phase and repeats the same comparison. This checks that no stale phase of the external clock survives the reset.

// File: rtl/cediv_pkg.sv
package cediv_pkg;
  // Default division ratio and high-phase length of the external clock
  localparam int unsigned DEF_DIV      = 25;
  localparam int unsigned DEF_HIGH_CYC = 12;
  localparam int unsigned DEF_SYNC     = 2;

  // Width needed to hold 0..div-1
  function automatic int unsigned cnt_width(input int unsigned div);
    int unsigned w;
    w = 1;
    while ((1 << w) < div) w++;
    return w;
  endfunction
endpackage

// File: rtl/cediv_rst_sync.sv
module cediv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cediv_mod_counter.sv
module cediv_mod_counter #(
  parameter int unsigned DIV = 25,
  parameter int unsigned W   = 5
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_q_o,
  output logic [W-1:0] cnt_d_o
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LAST); // R2
  AST_CNT_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && cnt_q == LAST) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/cediv_out_stage.sv
module cediv_out_stage #(
  parameter int unsigned DIV      = 25,
  parameter int unsigned HIGH_CYC = 12,
  parameter int unsigned W        = 5
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  input  logic [W-1:0] cnt_d_i,
  output logic         tick_o,
  output logic         ext_o
);
  localparam int unsigned CLR_INT = (DIV - 1 + HIGH_CYC) % DIV;
  localparam logic [W-1:0] TICK_AT = W'(DIV - 1);
  localparam logic [W-1:0] CLR_AT  = W'(CLR_INT);

  logic tick_q, tick_d;
  logic ext_q,  ext_d;

  always_comb begin
    tick_d = tick_q;
    ext_d  = ext_q;
    if (en_i) begin
      tick_d = (cnt_d_i == TICK_AT);
      if (cnt_d_i == TICK_AT)     ext_d = 1'b1;
      else if (cnt_d_i == CLR_AT) ext_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tick_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      ext_q  <= ext_d;
    end
  end

  assign tick_o = tick_q;
  assign ext_o  = ext_q;

  // Checker state: run lengths of the outputs
  logic [W-1:0] hi_run_q;
  logic [W-1:0] gap_q;
  logic         seen_tick_q;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hi_run_q    <= '0;
      gap_q       <= '0;
      seen_tick_q <= 1'b0;
    end else begin
      hi_run_q <= ext_q ? hi_run_q + 1'b1 : '0;
      gap_q    <= tick_q ? W'(1) : gap_q + 1'b1;
      if (tick_q) seen_tick_q <= 1'b1;
    end
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_q |=> !tick_q); // R3
  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick_q && seen_tick_q) |-> (gap_q == W'(DIV))); // R3
  AST_EXT_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(ext_q) |-> tick_q); // R5
  AST_TICK_WITH_EXT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_q |-> ext_q); // R5
  AST_EXT_HIGH_TIME: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ext_q && !ext_d && en_i) |-> (hi_run_q == W'(HIGH_CYC - 1))); // R6
  AST_EXT_LOW_BEFORE_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!seen_tick_q && !tick_q) |-> !ext_q); // R7
endmodule

// File: rtl/ce_clk_divider.sv
module ce_clk_divider #(
  parameter int unsigned DIV      = cediv_pkg::DEF_DIV,
  parameter int unsigned HIGH_CYC = cediv_pkg::DEF_HIGH_CYC,
  parameter int unsigned SYNC     = cediv_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic tick_o,
  output logic ext_clk_o
);
  localparam int unsigned W = cediv_pkg::cnt_width(DIV);

  logic         rst_int_n;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  cediv_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_int_n)
  );

  // Clock enable for the divider: running whenever out of reset
  assign cnt_en = rst_int_n;

  cediv_mod_counter #(.DIV(DIV), .W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_n_i (rst_int_n),
    .en_i    (cnt_en),
    .cnt_q_o (cnt_q),
    .cnt_d_o (cnt_d)
  );

  cediv_out_stage #(.DIV(DIV), .HIGH_CYC(HIGH_CYC), .W(W)) u_out (
    .clk_i   (clk_i),
    .rst_n_i (rst_int_n),
    .en_i    (cnt_en),
    .cnt_d_i (cnt_d),
    .tick_o  (tick_o),
    .ext_o   (ext_clk_o)
  );

  AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk_i)
    !rst_n_i |-> (!tick_o && !ext_clk_o)); // R1
  AST_CNT_ZERO_IN_RESET: assert property (@(posedge clk_i)
    !rst_int_n |-> (cnt_q == '0)); // R8
endmodule

// File: tb/sim_ce_clk_divider.sv
module sim_ce_clk_divider;
  localparam int DIV  = 25;
  localparam int HIGH = 12;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick, ext_clk;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  ce_clk_divider u0 (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .tick_o    (tick),
    .ext_clk_o (ext_clk)
  );

  task automatic check(input string req, input logic act, input logic exp, input int edge_no);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %b expected %b", req, edge_no, act, exp);
    end
  endtask

  // Model from the requirements: edge n after release (n starts at 1)
  function automatic logic exp_tick(input int n);
    return (n >= SYNC + DIV - 1) && (((n - (SYNC + DIV - 1)) % DIV) == 0);
  endfunction
  function automatic logic exp_ext(input int n);
    return (n >= SYNC + DIV - 1) && (((n - (SYNC + DIV - 1)) % DIV) < HIGH);
  endfunction

  // Release reset between edges, then compare after every edge
  task automatic release_and_track(input int edges, input string tag);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= edges; n++) begin
      @(posedge clk);
      #2;
      check({tag, " tick R3/R4"}, tick, exp_tick(n), n);
      check({tag, " ext R5/R6/R7"}, ext_clk, exp_ext(n), n);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    check("R1 reset tick", tick, 1'b0, 0);
    check("R1 reset ext", ext_clk, 1'b0, 0);
  endtask

  task automatic t_first_periods();
    // R4 R7: first strobe on edge 26, no early ext pulse; R2 R3 R5 R6 over 5 periods
    release_and_track(SYNC + 5 * DIV + 3, "R4 first");
  endtask

  task automatic t_async_and_restart();
    // Hit reset while ext_clk is high, between edges
    while (!ext_clk) @(negedge clk);
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check("R1 async tick", tick, 1'b0, -1);
    check("R1 async ext", ext_clk, 1'b0, -1);
    repeat (3) @(posedge clk);
    // R8: identical pattern after restart
    release_and_track(SYNC + 4 * DIV, "R8 restart");
  endtask

  task automatic t_long_run();
    // R2: repeat many periods
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    release_and_track(SYNC + 40 * DIV, "R2 long");
  endtask

  initial begin
    t_reset_state();
    t_first_periods();
    t_async_and_restart();
    t_long_run();
    t_reset_state();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule